// File: doc/BRIEF.md
# Lane-Splittable 64-bit Integer Multiplier

This block multiplies two 64-bit operands while treating them as a set of independent SIMD lanes. Seven split enables cut the word at byte boundaries, so the 64 bits can be any naturally aligned mix of 8-, 16-, 32- and 64-bit lanes. Each lane returns one half of its double-width product. It can return the low half, or the high half with the operands read as signed×signed, signed×unsigned or unsigned×unsigned. Every lane shares one array of byte-by-byte partial products. Byte pairs that straddle an active split are switched off.

Signed operands are handled by adding correction terms to the unsigned product. These are the inverted, shifted opposite operands, with the "+1" of the two's-complement negation injected at each lane's lowest bit. A masked carry-save stage and a partitioned ripple adder combine everything in a 128-bit space in which the split points sit at twice their input positions. Carries therefore never cross from one lane into the next. A byte-wise selector then moves the requested half of each lane back to the lane's own byte positions.

The datapath sits between two register stages under a valid/ready handshake. The split enables and op codes travel with the operands.

Top module: `simdPartMul`

## Requirements
- R1: A transaction accepted at a clock edge (inValid and inReady both high) shows up on outValid/result after the second rising edge that follows. That is a latency of two cycles when outReady is held high.
- R2: While outValid is high and outReady is low, outValid and result hold steady. When both stages are full and the output is stalled, inReady is low.
- R3: After reset, outValid is low and inReady is high.
- R4: Split bit p-1 (p = 1..7) high places a lane boundary between byte p-1 and byte p. Any aligned mix of 8/16/32/64-bit lanes gives each lane its own product.
- R5: Op code 0 returns the low half (lane width) of the lane's product. For the low half, signedness does not matter.
- R6: Op code 1 returns the high half of the product, with both operands signed.
- R7: Op code 2 returns the high half of the product, with a signed and b unsigned.
- R8: Op code 3 returns the high half of the product, with both operands unsigned.
- R9: Bits [2k+1:2k] of laneOps hold the code for byte k. A lane uses the code of its lowest byte, and the codes of its other bytes have no effect.
- R10: A lane's result depends only on the operand bytes inside that lane. No carry or borrow crosses a lane boundary.
- R11: Most-negative operands (MSB set, all other bits clear) give the mathematically correct result in every signed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand set is offered |
| inReady | output | 1 | Block accepts the offered set |
| opA | input | 64 | First operand, all lanes |
| opB | input | 64 | Second operand, all lanes |
| laneSplit | input | 7 | Bit p-1 high: lane boundary below byte p |
| laneOps | input | 16 | Two-bit op code per byte |
| outValid | output | 1 | Result is presented |
| outReady | input | 1 | Consumer takes the result |
| result | output | 64 | Per-lane selected product halves |

## Verification
A single 64-bit lane is exercised in all four modes with signed extremes. This shows whether the correction terms and the half selection are right before any partitioning is involved. All-byte lanes with mixed codes, and several fixed mixed splits, show whether the split points are decoded correctly. Most-negative and all-ones operands target the case where both correction terms are active and the borrow runs furthest. Random aligned splits and codes are compared against a per-lane reference. Two targeted runs cover the remaining rules. One changes only a neighbouring lane, to expose carry leakage. The other gives upper bytes conflicting codes, to show that a lane takes its op code from its lowest byte. A stalled-output run checks hold and backpressure.

// File: rtl/simdMulPkg.sv
package simdMulPkg;
  typedef enum logic [1:0] {
    OP_LOW    = 2'd0,
    OP_SHIGH  = 2'd1,
    OP_SUHIGH = 2'd2,
    OP_UHIGH  = 2'd3
  } mulOp_e;

  typedef struct packed {
    logic loadIn;   // stage 0 captures new operands
    logic loadOut;  // stage 1 captures the computed result
  } mulStrobe_t;
endpackage

// File: rtl/simdMulCtrl.sv
module simdMulCtrl
  import simdMulPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output mulStrobe_t strobe
);
  logic stageValid0, stageValid1;

  assign strobe.loadOut = !stageValid1 || outReady;
  assign strobe.loadIn  = !stageValid0 || strobe.loadOut;
  assign inReady        = strobe.loadIn;
  assign outValid       = stageValid1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid0 <= 1'b0;
      stageValid1 <= 1'b0;
    end else begin
      if (strobe.loadIn)  stageValid0 <= inValid;
      if (strobe.loadOut) stageValid1 <= stageValid0;
    end
  end

  // R2: a full pipe with a stalled consumer refuses new work
  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stageValid0 && stageValid1 && !outReady) |-> !inReady);

  // R2: a presented result is not withdrawn while stalled
  p_hold_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R1: an accepted transaction reaches the output stage on the next edge when it is free
  p_advance_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stageValid0 && (!stageValid1 || outReady)) |=> outValid);
endmodule

// File: rtl/simdPartAdder.sv
module simdPartAdder #(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] laneStart,  // carry chain restarts here with carry-in 1
  output logic [WIDTH-1:0] sum
);
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (laneStart[i]) c = 1'b1;
      sum[i] = x[i] ^ y[i] ^ c;
      c = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
    end
  end
endmodule

// File: rtl/simdMulDatapath.sv
module simdMulDatapath
  import simdMulPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  mulStrobe_t                strobe,
  input  logic [BYTE_W*N_BYTES-1:0] opA,
  input  logic [BYTE_W*N_BYTES-1:0] opB,
  input  logic [N_BYTES-2:0]        laneSplit,
  input  logic [2*N_BYTES-1:0]      laneOps,
  output logic [BYTE_W*N_BYTES-1:0] result
);
  localparam int W    = BYTE_W * N_BYTES;
  localparam int DW   = 2 * W;
  localparam int IDXW = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam int PPW  = 2 * BYTE_W;

  // stage 0: operands together with their lane layout and codes
  logic [W-1:0]         aR, bR;
  logic [N_BYTES-2:0]   peR;
  logic [2*N_BYTES-1:0] opsR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aR <= '0; bR <= '0; peR <= '0; opsR <= '0;
    end else if (strobe.loadIn) begin
      aR <= opA; bR <= opB; peR <= laneSplit; opsR <= laneOps;
    end
  end

  // lane bounds for every byte
  logic [IDXW-1:0] laneLo [N_BYTES];
  logic [IDXW-1:0] laneHi [N_BYTES];

  always_comb begin
    int s;
    int e;
    s = 0;
    for (int k = 0; k < N_BYTES; k++) begin
      if (k > 0 && peR[k-1]) s = k;
      laneLo[k] = IDXW'(s);
    end
    e = N_BYTES - 1;
    for (int k = N_BYTES - 1; k >= 0; k--) begin
      if (k < N_BYTES - 1 && peR[k]) e = k;
      laneHi[k] = IDXW'(e);
    end
  end

  // per-byte lane operation taken from the lane's lowest byte
  mulOp_e          laneOp [N_BYTES];
  logic [N_BYTES-1:0] signA, signB;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_op
    assign laneOp[g] = mulOp_e'(opsR[2*int'(laneLo[g]) +: 2]);
    assign signA[g]  = (laneOp[g] == OP_SHIGH) || (laneOp[g] == OP_SUHIGH);
    assign signB[g]  = (laneOp[g] == OP_SHIGH);
  end

  // unsigned partial products of in-lane byte pairs, in the doubled space
  logic [DW-1:0] prodU;
  always_comb begin
    logic [PPW-1:0] pp;
    prodU = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      for (int j = 0; j < N_BYTES; j++) begin
        pp = PPW'(aR[BYTE_W*i +: BYTE_W]) * PPW'(bR[BYTE_W*j +: BYTE_W]);
        if (laneLo[i] == laneLo[j])
          prodU = prodU + (DW'(pp) << (BYTE_W * (i + j)));
      end
    end
  end

  // sign corrections: subtract the other operand shifted up by the lane width
  logic [DW-1:0] rawA, rawB, termA, termB, dblStart;
  always_comb begin
    int d;
    int hi;
    logic aNeg, bNeg;
    rawA = '0;
    rawB = '0;
    for (int k = 0; k < N_BYTES; k++) begin
      hi   = int'(laneHi[k]);
      d    = k + hi + 1;
      aNeg = signA[k] && aR[BYTE_W*hi + BYTE_W - 1];
      bNeg = signB[k] && bR[BYTE_W*hi + BYTE_W - 1];
      rawA[BYTE_W*d +: BYTE_W] = aNeg ? bR[BYTE_W*k +: BYTE_W] : '0;
      rawB[BYTE_W*d +: BYTE_W] = bNeg ? aR[BYTE_W*k +: BYTE_W] : '0;
    end
    dblStart    = '0;
    dblStart[0] = 1'b1;
    for (int p = 1; p < N_BYTES; p++)
      if (peR[p-1]) dblStart[2*BYTE_W*p] = 1'b1;
  end

  assign termA = ~rawA;
  assign termB = ~rawB;

  // masked 3:2 compression; first +1 per lane enters at the vacated carry slot
  logic [DW-1:0] csaSum, csaCarryRaw, csaCarry, fullSum;
  assign csaSum      = prodU ^ termA ^ termB;
  assign csaCarryRaw = (prodU & termA) | (prodU & termB) | (termA & termB);
  assign csaCarry    = ({csaCarryRaw[DW-2:0], 1'b0} & ~dblStart) | dblStart;

  // second +1 per lane is the carry-in at each lane start
  simdPartAdder #(.WIDTH(DW)) u_add (
    .x(csaSum), .y(csaCarry), .laneStart(dblStart), .sum(fullSum)
  );

  // half selection back into lane position
  logic [W-1:0] resComb;
  always_comb begin
    int src;
    for (int k = 0; k < N_BYTES; k++) begin
      src = (laneOp[k] == OP_LOW) ? int'(laneLo[k]) + k : k + int'(laneHi[k]) + 1;
      resComb[BYTE_W*k +: BYTE_W] = fullSum[BYTE_W*src +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) result <= '0;
    else if (strobe.loadOut) result <= resComb;
  end

  // R5: all-byte lanes in low mode give each byte's own low product
  for (genvar g = 0; g < N_BYTES; g++) begin : g_chk
    p_byte_low_r5: assert property (@(posedge clk) disable iff (!rstN)
      ((&peR) && (opsR == '0)) |->
      (resComb[BYTE_W*g +: BYTE_W] ==
       BYTE_W'(aR[BYTE_W*g +: BYTE_W] * bR[BYTE_W*g +: BYTE_W])));
  end

  // R11: most-negative squared in signed high mode on byte lanes
  p_min_square_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((&peR) && (opsR == {N_BYTES{2'b01}}) &&
     (aR == {N_BYTES{{1'b1, {(BYTE_W-1){1'b0}}}}}) &&
     (bR == {N_BYTES{{1'b1, {(BYTE_W-1){1'b0}}}}})) |->
    (resComb == {N_BYTES{{2'b01, {(BYTE_W-2){1'b0}}}}}));
endmodule

// File: rtl/simdPartMul.sv
module simdPartMul
  import simdMulPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [BYTE_W*N_BYTES-1:0] opA,
  input  logic [BYTE_W*N_BYTES-1:0] opB,
  input  logic [N_BYTES-2:0]        laneSplit,
  input  logic [2*N_BYTES-1:0]      laneOps,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [BYTE_W*N_BYTES-1:0] result
);
  mulStrobe_t strobe;

  simdMulCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  simdMulDatapath #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .laneSplit(laneSplit), .laneOps(laneOps), .result(result)
  );

  // R2: stalled result keeps its value
  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(result));
endmodule

// File: tb/tb_simdPartMul.sv
module tb_simdPartMul;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] opA = '0, opB = '0;
  logic [6:0]  laneSplit = '0;
  logic [15:0] laneOps = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simdPartMul dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .laneSplit(laneSplit), .laneOps(laneOps),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-lane reference: code from lowest byte of each lane
  function automatic logic [63:0] refMul(input logic [63:0] a, input logic [63:0] b,
                                         input logic [6:0] sp, input logic [15:0] ops);
    logic [63:0]  res;
    logic [127:0] xa, xb, prod, mask;
    int k, e, w;
    logic [1:0] op;
    bit sa, sb;
    res = '0;
    k = 0;
    while (k < NB) begin
      e = k;
      while (e < NB - 1 && !sp[e]) e++;
      w = e - k + 1;
      op = ops[2*k +: 2];
      sa = (op == 2'd1) || (op == 2'd2);
      sb = (op == 2'd1);
      mask = (128'd1 << (8*w)) - 1;
      xa = (128'(a) >> (8*k)) & mask;
      xb = (128'(b) >> (8*k)) & mask;
      if (sa && xa[8*w-1]) xa = xa | ~mask;
      if (sb && xb[8*w-1]) xb = xb | ~mask;
      prod = xa * xb;
      if (op != 2'd0) prod = prod >> (8*w);
      prod = prod & mask;
      res = res | (64'(prod) << (8*k));
      k = e + 1;
    end
    return res;
  endfunction

  function automatic logic [15:0] spreadOps(input logic [6:0] sp, input logic [15:0] seed);
    logic [15:0] o;
    int s;
    s = 0;
    for (int k = 0; k < NB; k++) begin
      if (k > 0 && sp[k-1]) s = k;
      o[2*k +: 2] = seed[2*s +: 2];
    end
    return o;
  endfunction

  function automatic logic [6:0] randSplit();
    logic [6:0] sp;
    int k, w;
    sp = '0;
    k = 0;
    while (k < NB) begin
      do w = 1 << ($urandom % 4); while ((k % w) != 0 || k + w > NB);
      if (k + w < NB) sp[k+w-1] = 1'b1;
      k = k + w;
    end
    return sp;
  endfunction

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input logic [6:0] sp,
                       input logic [15:0] ops, input string tag, output logic [63:0] got);
    int lat;
    logic [63:0] exp;
    exp = refMul(a, b, sp, ops);
    @(negedge clk);
    opA = a; opB = b; laneSplit = sp; laneOps = ops;
    inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    lat = 1;
    while (!outValid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 2, {tag, " R1 latency"}, 64'(lat), 64'd2);
    check(result == exp, tag, result, exp);
    got = result;
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R3 outValid after reset", 64'(outValid), 64'd0);
    check(inReady == 1'b1, "R3 inReady after reset", 64'(inReady), 64'd1);
  endtask

  task automatic testWideLane();
    logic [63:0] g;
    logic [63:0] vals [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                              64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210};
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 4; i++) begin
        string t;
        case (op)
          0: t = "R5 low 64";
          1: t = "R6 signed high 64";
          2: t = "R7 signed-unsigned high 64";
          default: t = "R8 unsigned high 64";
        endcase
        runOp(vals[i], vals[(i+1)%4], 7'h00, {8{2'(op)}}, t, g);
      end
  endtask

  task automatic testByteLanes();
    logic [63:0] g;
    runOp(64'hFF80_7F01_C3A5_0203, 64'h80FF_7F02_3C5A_FF81, 7'h7F, 16'b11_10_01_00_11_10_01_00, "R4 byte lanes mixed ops", g);
    runOp(64'h0102_0304_0506_0708, 64'hF0E0_D0C0_B0A0_9080, 7'h7F, 16'h0000, "R5 byte lanes low", g);
  endtask

  task automatic testMixedSplits();
    logic [63:0] g;
    runOp(64'h8000_FFFF_8000_1234, 64'hFFFF_8000_7FFF_8765, 7'b0101010, spreadOps(7'b0101010, 16'h1B1B), "R4 16-bit lanes", g);
    runOp(64'h8000_0000_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000, 7'b0001000, spreadOps(7'b0001000, 16'h00C0), "R4 32-bit lanes", g);
    runOp(64'h89AB_CDEF_8001_FF80, 64'hFEDC_BA98_FFFF_807F, 7'b0001011, spreadOps(7'b0001011, 16'h00E4), "R4 mixed 8/16/32", g);
    runOp(64'hFF80_8001_1234_5678, 64'h80FF_FFFF_8765_4321, 7'b0111000, spreadOps(7'b0111000, 16'h2D00), "R4 mixed 32/8/8/16", g);
  endtask

  task automatic testMostNegative();
    logic [63:0] g;
    logic [6:0] sps [4] = '{7'h00, 7'b0001000, 7'b0101010, 7'h7F};
    logic [63:0] mins [4] = '{64'h8000_0000_0000_0000, 64'h8000_0000_8000_0000,
                              64'h8000_8000_8000_8000, 64'h8080_8080_8080_8080};
    for (int i = 0; i < 4; i++) begin
      runOp(mins[i], mins[i], sps[i], 16'h5555, "R11 min*min signed", g);
      runOp(mins[i], 64'hFFFF_FFFF_FFFF_FFFF, sps[i], 16'h5555, "R11 min*-1 signed", g);
      runOp(mins[i], 64'hFFFF_FFFF_FFFF_FFFF, sps[i], 16'hAAAA, "R11 min*max unsigned b", g);
      runOp(mins[i], mins[i], sps[i], 16'h0000, "R11 min*min low", g);
    end
  endtask

  task automatic testLowByteCode();
    logic [63:0] g;
    // two 32-bit lanes: lowest bytes say 1 and 3, upper bytes carry other codes
    runOp(64'hF123_4567_89AB_CDEF, 64'h8765_4321_FEDC_BA98, 7'b0001000, 16'b00_10_00_11_10_10_00_01, "R9 lowest byte code", g);
    runOp(64'h8000_0001_FFFF_FFFE, 64'h7FFF_FFFF_8000_0000, 7'b0001000, 16'b11_01_11_00_01_11_01_10, "R9 lowest byte code 2", g);
  endtask

  task automatic testIsolation();
    logic [63:0] g1, g2;
    runOp(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 7'b0001000, 16'hFFFF, "R10 neighbour zero", g1);
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 7'b0001000, 16'hFFFF, "R10 neighbour ones", g2);
    check(g1[31:0] == g2[31:0], "R10 low lane unchanged by neighbour", 64'(g2[31:0]), 64'(g1[31:0]));
    runOp(64'h00FF_00FF_00FF_00FF, 64'h00FF_00FF_00FF_00FF, 7'h7F, 16'h0000, "R10 byte lanes low no spill", g1);
    check(g1 == 64'h0001_0001_0001_0001, "R10 no carry across bytes", g1, 64'h0001_0001_0001_0001);
  endtask

  task automatic testRandom();
    logic [63:0] g;
    for (int i = 0; i < 60; i++) begin
      logic [6:0] sp;
      sp = randSplit();
      runOp({$urandom, $urandom}, {$urandom, $urandom}, sp,
            spreadOps(sp, 16'($urandom)), "R4 random split", g);
    end
  endtask

  task automatic testBackpressure();
    logic [63:0] eA, eB;
    eA = refMul(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 7'h00, 16'h0000);
    eB = refMul(64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 7'h00, 16'h5555);
    @(negedge clk);
    outReady = 1'b0;
    opA = 64'h1111_2222_3333_4444; opB = 64'h5555_6666_7777_8888; laneSplit = 7'h00; laneOps = 16'h0000;
    inValid = 1'b1;
    @(negedge clk);
    opA = 64'h8000_0000_0000_0001; opB = 64'hFFFF_FFFF_FFFF_FFFF; laneOps = 16'h5555;
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R2 inReady low when full", 64'(inReady), 64'd0);
    check(outValid == 1'b1, "R2 first result presented", 64'(outValid), 64'd1);
    check(result == eA, "R2 first result value", result, eA);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(outValid == 1'b1 && result == eA, "R2 held while stalled", result, eA);
    outReady = 1'b1;
    @(negedge clk);
    check(outValid == 1'b1 && result == eB, "R2 second result after release", result, eB);
    @(negedge clk);
    check(outValid == 1'b0, "R2 drained", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWideLane();
    testByteLanes();
    testMixedSplits();
    testMostNegative();
    testLowByteCode();
    testIsolation();
    testRandom();
    testBackpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule